// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block connects two bidirectional data buses, A and B, with a default width of 8 bits. Each bus appears as three port groups: the value seen on the bus, the value the block would drive, and a per-bit output enable. An outside resolution stage or pad ring then builds the real bus, so the block itself needs no tri-state logic. Data passes in both directions without inversion.

Each direction has its own capture register with its own clock. The A-to-B register samples bus A, and the B-to-A register samples bus B. Both registers clear on an asynchronous reset. Capture on a clock edge happens whatever the source selects and output enables are set to. For each direction, a source select chooses what is driven onto the far bus: the live value of the near bus or the stored register value.

An active-high direction enable lets the block drive bus B. An active-low output enable lets it drive bus A. With both sources live and both sides driving, each bus feeds the other through the block. Once every outside driver lets go, both buses stay at their last value.

Top module: `regbus_xcvr`

## Requirements
- R1: While rst_ni is low, both capture registers are zero. With a source select at 1 (stored), the driven value for that direction reads all zeros.
- R2: On a rising edge of clk_ab_i, the A-to-B register loads a_i. This happens for every setting of sel_ab_i, sel_ba_i, dir_en_i and oe_ni.
- R3: On a rising edge of clk_ba_i, the B-to-A register loads b_i. This happens for every setting of sel_ab_i, sel_ba_i, dir_en_i and oe_ni.
- R4: When sel_ab_i is 0 (live), b_o equals a_i bit for bit in the same cycle.
- R5: When sel_ab_i is 1 (stored), b_o equals the A-to-B register. It does not follow a_i.
- R6: When sel_ba_i is 0, a_o equals b_i. When sel_ba_i is 1, a_o equals the B-to-A register.
- R7: b_oe_o is all ones when dir_en_i is 1 and all zeros when dir_en_i is 0.
- R8: a_oe_o is all ones when oe_ni is 0 and all zeros when oe_ni is 1.
- R9: If clk_ab_i and clk_ba_i rise on the same edge, both registers load on that edge.
- R10: With sel_ab_i=0, sel_ba_i=0, dir_en_i=1 and oe_ni=0, both buses keep their last value after the outside drivers release them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Asynchronous active-low reset of both registers |
| clk_ab_i | input | 1 | Capture clock of the A-to-B register |
| clk_ba_i | input | 1 | Capture clock of the B-to-A register |
| sel_ab_i | input | 1 | B-side source: 0 live bus A, 1 stored |
| sel_ba_i | input | 1 | A-side source: 0 live bus B, 1 stored |
| dir_en_i | input | 1 | Active-high enable for driving bus B |
| oe_ni | input | 1 | Active-low enable for driving bus A |
| a_i | input | WIDTH | Value seen on bus A |
| a_o | output | WIDTH | Value driven onto bus A |
| a_oe_o | output | WIDTH | Per-bit drive enable for bus A |
| b_i | input | WIDTH | Value seen on bus B |
| b_o | output | WIDTH | Value driven onto bus B |
| b_oe_o | output | WIDTH | Per-bit drive enable for bus B |

## Verification
Two things can land in the same cycle: a capture and a drive of the same bus. The bench provokes this by pulsing a capture clock while that direction is in stored mode and its output enable is on, or while the far side is in live mode and driving. It then checks that the new stored value shows up on the far output only after the edge. In a second case, both capture clocks rise on one edge while the two buses carry different patterns, and the bench checks that each register holds its own bus's pattern. The hold loop is judged with a bench-side bus resolver: outside drivers are released one at a time, and the bench confirms that the resolved buses keep their values.

// File: rtl/regbus_xcvr_pkg.sv
package regbus_xcvr_pkg;
  typedef enum logic {
    SRC_LIVE   = 1'b0,
    SRC_STORED = 1'b1
  } src_sel_e;

  localparam int unsigned NUM_DIR = 2;
  localparam int unsigned DIR_AB  = 0;
  localparam int unsigned DIR_BA  = 1;
endpackage

// File: rtl/regbus_xcvr_capture.sv
module regbus_xcvr_capture #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= d_i;
  end
endmodule

// File: rtl/regbus_xcvr_src_mux.sv
module regbus_xcvr_src_mux
  import regbus_xcvr_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  src_sel_e         sel_i,
  input  logic [WIDTH-1:0] live_i,
  input  logic [WIDTH-1:0] stored_i,
  output logic [WIDTH-1:0] data_o
);
  always_comb begin
    unique case (sel_i)
      SRC_STORED: data_o = stored_i;
      default:    data_o = live_i;
    endcase
  end
endmodule

// File: rtl/regbus_xcvr_drive.sv
module regbus_xcvr_drive #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             en_i,
  input  logic [WIDTH-1:0] data_i,
  output logic [WIDTH-1:0] data_o,
  output logic [WIDTH-1:0] oe_o
);
  // data always presented; enable decides whether the pad drives
  assign data_o = data_i;
  assign oe_o   = {WIDTH{en_i}};
endmodule

// File: rtl/regbus_xcvr.sv
module regbus_xcvr
  import regbus_xcvr_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             rst_ni,
  input  logic             clk_ab_i,
  input  logic             clk_ba_i,
  input  logic             sel_ab_i,
  input  logic             sel_ba_i,
  input  logic             dir_en_i,
  input  logic             oe_ni,
  input  logic [WIDTH-1:0] a_i,
  output logic [WIDTH-1:0] a_o,
  output logic [WIDTH-1:0] a_oe_o,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] b_o,
  output logic [WIDTH-1:0] b_oe_o
);
  localparam int unsigned ND = NUM_DIR;

  // index DIR_AB: source bus A, sink bus B; DIR_BA the reverse
  logic [ND-1:0]            cap_clk;
  logic [ND-1:0]            drv_en;
  src_sel_e [ND-1:0]        src_sel;
  logic [ND-1:0][WIDTH-1:0] near_bus;
  logic [ND-1:0][WIDTH-1:0] stored;
  logic [ND-1:0][WIDTH-1:0] muxed;
  logic [ND-1:0][WIDTH-1:0] far_data;
  logic [ND-1:0][WIDTH-1:0] far_oe;

  assign cap_clk[DIR_AB]  = clk_ab_i;
  assign cap_clk[DIR_BA]  = clk_ba_i;
  assign src_sel[DIR_AB]  = src_sel_e'(sel_ab_i);
  assign src_sel[DIR_BA]  = src_sel_e'(sel_ba_i);
  assign near_bus[DIR_AB] = a_i;
  assign near_bus[DIR_BA] = b_i;
  assign drv_en[DIR_AB]   = dir_en_i;
  assign drv_en[DIR_BA]   = ~oe_ni;

  for (genvar d = 0; d < ND; d++) begin : g_dir
    regbus_xcvr_capture #(.WIDTH(WIDTH)) u_cap (
      .clk_i  (cap_clk[d]),
      .rst_ni (rst_ni),
      .d_i    (near_bus[d]),
      .q_o    (stored[d])
    );

    regbus_xcvr_src_mux #(.WIDTH(WIDTH)) u_mux (
      .sel_i    (src_sel[d]),
      .live_i   (near_bus[d]),
      .stored_i (stored[d]),
      .data_o   (muxed[d])
    );

    regbus_xcvr_drive #(.WIDTH(WIDTH)) u_drv (
      .en_i   (drv_en[d]),
      .data_i (muxed[d]),
      .data_o (far_data[d]),
      .oe_o   (far_oe[d])
    );
  end

  assign b_o    = far_data[DIR_AB];
  assign b_oe_o = far_oe[DIR_AB];
  assign a_o    = far_data[DIR_BA];
  assign a_oe_o = far_oe[DIR_BA];
endmodule

// File: rtl/regbus_xcvr_chk.sv
module regbus_xcvr_chk #(
  parameter int unsigned WIDTH = 8
) (
  input logic             rst_ni,
  input logic             clk_ab_i,
  input logic             clk_ba_i,
  input logic             sel_ab_i,
  input logic             sel_ba_i,
  input logic             dir_en_i,
  input logic             oe_ni,
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] a_o,
  input logic [WIDTH-1:0] a_oe_o,
  input logic [WIDTH-1:0] b_i,
  input logic [WIDTH-1:0] b_o,
  input logic [WIDTH-1:0] b_oe_o
);
  logic seen_ab, seen_ba;

  always_ff @(posedge clk_ab_i or negedge rst_ni) begin
    if (!rst_ni) seen_ab <= 1'b0;
    else         seen_ab <= 1'b1;
  end

  always_ff @(posedge clk_ba_i or negedge rst_ni) begin
    if (!rst_ni) seen_ba <= 1'b0;
    else         seen_ba <= 1'b1;
  end

  a_r1_reset_clear: assert property (@(posedge clk_ab_i)
    (!rst_ni && sel_ab_i) |-> (b_o == '0));

  a_r2_capture_a: assert property (@(posedge clk_ab_i) disable iff (!rst_ni)
    (seen_ab && sel_ab_i) |-> (b_o == $past(a_i)));

  a_r3_capture_b: assert property (@(posedge clk_ba_i) disable iff (!rst_ni)
    (seen_ba && sel_ba_i) |-> (a_o == $past(b_i)));

  a_r4_live_ab: assert property (@(posedge clk_ab_i) disable iff (!rst_ni)
    !sel_ab_i |-> (b_o == a_i));

  a_r6_live_ba: assert property (@(posedge clk_ba_i) disable iff (!rst_ni)
    !sel_ba_i |-> (a_o == b_i));

  a_r7_b_enable: assert property (@(posedge clk_ab_i) disable iff (!rst_ni)
    dir_en_i ? ($countones(b_oe_o) == WIDTH) : ($countones(b_oe_o) == 0));

  a_r8_a_enable: assert property (@(posedge clk_ba_i) disable iff (!rst_ni)
    oe_ni ? ($countones(a_oe_o) == 0) : ($countones(a_oe_o) == WIDTH));
endmodule

bind regbus_xcvr regbus_xcvr_chk #(.WIDTH(WIDTH)) u_chk (
  .rst_ni   (rst_ni),
  .clk_ab_i (clk_ab_i),
  .clk_ba_i (clk_ba_i),
  .sel_ab_i (sel_ab_i),
  .sel_ba_i (sel_ba_i),
  .dir_en_i (dir_en_i),
  .oe_ni    (oe_ni),
  .a_i      (a_i),
  .a_o      (a_o),
  .a_oe_o   (a_oe_o),
  .b_i      (b_i),
  .b_o      (b_o),
  .b_oe_o   (b_oe_o)
);

// File: tb/tb_regbus_xcvr.sv
`timescale 1ns/1ps
module tb_regbus_xcvr;
  localparam int W = 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, clk_ab, clk_ba, sel_ab, sel_ba, dir_en, oe_n;
  logic [W-1:0] a_o, a_oe, b_o, b_oe;
  logic [W-1:0] ext_a, ext_b;
  logic ext_a_en, ext_b_en;
  logic [W-1:0] bus_a, bus_b;

  // bus resolution: outside driver wins; otherwise enabled block bits; idle bits read 0
  assign bus_a = ext_a_en ? ext_a : (a_o & a_oe);
  assign bus_b = ext_b_en ? ext_b : (b_o & b_oe);

  regbus_xcvr #(.WIDTH(W)) dut (
    .rst_ni(rst_n), .clk_ab_i(clk_ab), .clk_ba_i(clk_ba),
    .sel_ab_i(sel_ab), .sel_ba_i(sel_ba), .dir_en_i(dir_en), .oe_ni(oe_n),
    .a_i(bus_a), .a_o(a_o), .a_oe_o(a_oe),
    .b_i(bus_b), .b_o(b_o), .b_oe_o(b_oe)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic settle();
    @(negedge clk); #1;
  endtask

  task automatic pulse(input bit ab, input bit ba);
    @(negedge clk);
    clk_ab = ab; clk_ba = ba;
    @(negedge clk);
    clk_ab = 1'b0; clk_ba = 1'b0;
    #1;
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; clk_ab = 0; clk_ba = 0;
    sel_ab = 1; sel_ba = 1; dir_en = 0; oe_n = 1;
    ext_a = 8'h5a; ext_b = 8'ha5; ext_a_en = 1; ext_b_en = 1;
    settle();
    // R1: stored outputs zero in reset
    chk("R1 b_o", b_o, '0);
    chk("R1 a_o", a_o, '0);
    settle();
    rst_n = 1;
    settle();
    chk("R1 b_o after release", b_o, '0);
    chk("R1 a_o after release", a_o, '0);

    // R4/R6 live sweep, R7/R8 idle enables
    sel_ab = 0; sel_ba = 0;
    for (int v = 0; v < 256; v++) begin
      ext_a = v[W-1:0]; ext_b = ~v[W-1:0];
      #1;
      chk("R4 live a->b", b_o, v[W-1:0]);
      chk("R6 live b->a", a_o, ~v[W-1:0]);
      chk("R7 b_oe idle", b_oe, '0);
      chk("R8 a_oe idle", a_oe, '0);
    end

    // R7/R8 enable decode over all combos
    for (int k = 0; k < 4; k++) begin
      dir_en = k[0]; oe_n = k[1];
      #1;
      chk("R7 b_oe", b_oe, {W{k[0]}});
      chk("R8 a_oe", a_oe, {W{~k[1]}});
    end

    // R2/R3/R5/R6 capture sweep over every control setting
    for (int v = 0; v < 256; v++) begin
      sel_ab = v[0]; sel_ba = v[1]; dir_en = v[2]; oe_n = v[3];
      ext_a = v[W-1:0] ^ 8'h3c; ext_b = v[W-1:0] ^ 8'hc3;
      pulse(1'b1, 1'b0);
      pulse(1'b0, 1'b1);
      sel_ab = 1; sel_ba = 1;
      ext_a = ~ext_a; ext_b = ~ext_b;
      #1;
      chk("R2/R5 stored a->b", b_o, v[W-1:0] ^ 8'h3c);
      chk("R3/R6 stored b->a", a_o, v[W-1:0] ^ 8'hc3);
    end

    // R9 simultaneous capture
    for (int v = 0; v < 64; v++) begin
      sel_ab = 1; sel_ba = 1; dir_en = 1; oe_n = 0;
      ext_a = v[W-1:0] * 8'd7; ext_b = 8'hff - v[W-1:0];
      pulse(1'b1, 1'b1);
      chk("R9 both a", b_o, v[W-1:0] * 8'd7);
      chk("R9 both b", a_o, 8'hff - v[W-1:0]);
    end

    // R10 hold loop
    sel_ab = 0; sel_ba = 0; dir_en = 1; oe_n = 0;
    for (int v = 0; v < 32; v++) begin
      ext_a = v[W-1:0] * 8'd9 + 8'd1; ext_a_en = 1; ext_b_en = 0;
      #1;
      chk("R10 b follows a", bus_b, v[W-1:0] * 8'd9 + 8'd1);
      ext_a_en = 0;
      settle();
      chk("R10 hold a", bus_a, v[W-1:0] * 8'd9 + 8'd1);
      chk("R10 hold b", bus_b, v[W-1:0] * 8'd9 + 8'd1);
      ext_b = ~(v[W-1:0] * 8'd5); ext_b_en = 1;
      #1;
      chk("R10 a follows b", bus_a, ~(v[W-1:0] * 8'd5));
      ext_b_en = 0;
      settle();
      chk("R10 hold a2", bus_a, ~(v[W-1:0] * 8'd5));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule